// File: doc/BRIEF.md
# Registered Octal Bus Transceiver

This block sits between two 8-bit buses, A and B. Each transfer direction has its own storage register with its own clock. The A-to-B register takes a snapshot of bus A on the falling edge of its clock, and the B-to-A register takes a snapshot of bus B on the falling edge of its clock. Data passes through without inversion.

For each direction, a select input chooses what the receiving bus is driven with. It is either the live value on the opposite bus or the value held in that direction's register. An active-low output enable and a direction input together decide which bus, if either, is driven. The block is built for synthesis, so each bidirectional bus appears as three ports: an input vector, an output vector and a single drive-enable bit. The output vector always carries the selected data, and the drive-enable bit says whether the pins are actually driven.

The drive decoder has three named modes:
- `DRV_NONE`: both buses idle.
- `DRV_A_TO_B`: bus B is driven.
- `DRV_B_TO_A`: bus A is driven.

The mode is decoded with no memory of its own, so every transition is immediate:
- Any mode goes to `DRV_NONE` when `oe_n` rises.
- `DRV_NONE` goes to `DRV_A_TO_B` when `oe_n` falls with `dir` high, or to `DRV_B_TO_A` when it falls with `dir` low.
- `DRV_A_TO_B` and `DRV_B_TO_A` swap whenever `dir` toggles while `oe_n` is low.

Top module: `xcvr_reg_octal`

## Requirements
- R1: While `oe_n` is 1, both `a_oe` and `b_oe` are 0.
- R2: While `oe_n` is 0, `dir`=1 gives `b_oe`=1 with `a_oe`=0, and `dir`=0 gives `a_oe`=1 with `b_oe`=0.
- R3: `a_oe` and `b_oe` are never 1 together.
- R4: `b_out` equals `a_in` when `sel_ab`=0 and the A-to-B stored value when `sel_ab`=1, without inversion, in the same cycle as the select change.
- R5: `a_out` equals `b_in` when `sel_ba`=0 and the B-to-A stored value when `sel_ba`=1, without inversion, in the same cycle as the select change.
- R6: The A-to-B register loads `a_in` on a falling edge of `clk_ab` only. A rising edge, or a change of `a_in` between edges, leaves the stored value unchanged.
- R7: The B-to-A register loads `b_in` on a falling edge of `clk_ba` only.
- R8: Loads happen whatever the values of `oe_n` and `dir`, including while both buses are idle. Both registers may load in the same instant.
- R9: While `rst_n` is 0, both registers are cleared to 0 at once, without waiting for a clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low clear of both registers |
| clk_ab | input | 1 | A-to-B register clock, falling edge active |
| clk_ba | input | 1 | B-to-A register clock, falling edge active |
| oe_n | input | 1 | Active-low output enable |
| dir | input | 1 | 1: drive bus B, 0: drive bus A |
| sel_ab | input | 1 | Bus B source: 0 live A, 1 stored |
| sel_ba | input | 1 | Bus A source: 0 live B, 1 stored |
| a_in | input | 8 | Bus A pin values |
| a_out | output | 8 | Value for bus A pins |
| a_oe | output | 1 | Drive enable for bus A |
| b_in | input | 8 | Bus B pin values |
| b_out | output | 8 | Value for bus B pins |
| b_oe | output | 1 | Drive enable for bus B |

## Verification
The block's only internal state is the two stored bytes. A wrong stored byte stays hidden until the matching select is set to 1. From that moment it appears on the receiving output vector in the same cycle, with no delay. A wrong drive mode needs no such trigger: it shows at once on the two enable bits, either as both set or as the wrong bus being driven. For this reason, every stored-value check in the bench selects the register before sampling.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
    localparam int XCVR_WIDTH = 8;

    typedef enum logic [1:0] {
        DRV_NONE   = 2'd0,
        DRV_A_TO_B = 2'd1,
        DRV_B_TO_A = 2'd2
    } drive_mode_e;
endpackage

// File: rtl/xcvr_store_reg.sv
module xcvr_store_reg #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    // R6 / R7: the value seen after a falling edge is the data sampled at the previous one
    a_r6_capture: assert property (@(negedge clk) disable iff (!rst_n)
        1'b1 |=> (q == $past(d)));
endmodule

// File: rtl/xcvr_path_mux.sv
module xcvr_path_mux #(
    parameter int WIDTH = 8
) (
    input  logic             use_stored,
    input  logic [WIDTH-1:0] live,
    input  logic [WIDTH-1:0] stored,
    output logic [WIDTH-1:0] sel_out
);
    always_comb begin
        sel_out = use_stored ? stored : live;
    end
endmodule

// File: rtl/xcvr_drive_ctrl.sv
module xcvr_drive_ctrl
    import xcvr_pkg::*;
(
    input  logic        oe_n,
    input  logic        dir,
    output drive_mode_e mode,
    output logic        a_oe,
    output logic        b_oe
);
    always_comb begin
        unique case ({oe_n, dir})
            2'b01:   mode = DRV_A_TO_B;
            2'b00:   mode = DRV_B_TO_A;
            default: mode = DRV_NONE;
        endcase
    end

    always_comb begin
        a_oe = 1'b0;
        b_oe = 1'b0;
        unique case (mode)
            DRV_A_TO_B: b_oe = 1'b1;
            DRV_B_TO_A: a_oe = 1'b1;
            default: begin
                a_oe = 1'b0;
                b_oe = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/xcvr_reg_octal.sv
module xcvr_reg_octal
    import xcvr_pkg::*;
#(
    parameter int WIDTH = XCVR_WIDTH
) (
    input  logic             rst_n,
    input  logic             clk_ab,
    input  logic             clk_ba,
    input  logic             oe_n,
    input  logic             dir,
    input  logic             sel_ab,
    input  logic             sel_ba,
    input  logic [WIDTH-1:0] a_in,
    output logic [WIDTH-1:0] a_out,
    output logic             a_oe,
    input  logic [WIDTH-1:0] b_in,
    output logic [WIDTH-1:0] b_out,
    output logic             b_oe
);
    logic [WIDTH-1:0] stored_ab;
    logic [WIDTH-1:0] stored_ba;
    drive_mode_e      mode;

    xcvr_store_reg #(.WIDTH(WIDTH)) u_reg_ab (
        .clk(clk_ab), .rst_n(rst_n), .d(a_in), .q(stored_ab)
    );

    xcvr_store_reg #(.WIDTH(WIDTH)) u_reg_ba (
        .clk(clk_ba), .rst_n(rst_n), .d(b_in), .q(stored_ba)
    );

    xcvr_path_mux #(.WIDTH(WIDTH)) u_mux_b (
        .use_stored(sel_ab), .live(a_in), .stored(stored_ab), .sel_out(b_out)
    );

    xcvr_path_mux #(.WIDTH(WIDTH)) u_mux_a (
        .use_stored(sel_ba), .live(b_in), .stored(stored_ba), .sel_out(a_out)
    );

    xcvr_drive_ctrl u_drive (
        .oe_n(oe_n), .dir(dir), .mode(mode), .a_oe(a_oe), .b_oe(b_oe)
    );

    always_comb begin
        a_r3_one_driver: assert (!(a_oe && b_oe));
        if (oe_n) begin
            a_r1_idle: assert (!a_oe && !b_oe);
        end
        if (!oe_n) begin
            a_r2_dir_pick: assert (b_oe == dir && a_oe == !dir);
        end
        if (!sel_ab) begin
            a_r4_live_b: assert (b_out == a_in);
        end
        if (!sel_ba) begin
            a_r5_live_a: assert (a_out == b_in);
        end
    end
endmodule

// File: tb/tb_xcvr_reg_octal.sv
module tb_xcvr_reg_octal;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clk_ab = 1'b0;
    logic       clk_ba = 1'b0;
    logic       oe_n = 1'b1;
    logic       dir = 1'b0;
    logic       sel_ab = 1'b0;
    logic       sel_ba = 1'b0;
    logic [7:0] a_in = 8'h00;
    logic [7:0] b_in = 8'h00;
    logic [7:0] a_out;
    logic [7:0] b_out;
    logic       a_oe;
    logic       b_oe;

    int n_vec = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    xcvr_reg_octal dut (
        .rst_n(rst_n), .clk_ab(clk_ab), .clk_ba(clk_ba), .oe_n(oe_n), .dir(dir),
        .sel_ab(sel_ab), .sel_ba(sel_ba), .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
        .b_in(b_in), .b_out(b_out), .b_oe(b_oe)
    );

    // {oe_n, dir, sel_ab, sel_ba, expected a_oe, expected b_oe}
    localparam logic [5:0] VEC [16] = '{
        6'b0000_10, 6'b0001_10, 6'b0010_10, 6'b0011_10,
        6'b0100_01, 6'b0101_01, 6'b0110_01, 6'b0111_01,
        6'b1000_00, 6'b1001_00, 6'b1010_00, 6'b1011_00,
        6'b1100_00, 6'b1101_00, 6'b1110_00, 6'b1111_00
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic pulse_ab();
        clk_ab = 1'b1; #2; clk_ab = 1'b0; #2;
    endtask

    task automatic pulse_ba();
        clk_ba = 1'b1; #2; clk_ba = 1'b0; #2;
    endtask

    initial begin
        #100000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        // R9: cleared while reset is held
        oe_n = 1'b0; dir = 1'b1; sel_ab = 1'b1; sel_ba = 1'b1;
        #3;
        chk("R9 reset ab", b_out, 8'h00);
        chk("R9 reset ba", a_out, 8'h00);
        @(posedge clk); rst_n = 1'b1;

        // R8: load both registers while both buses are idle
        oe_n = 1'b1;
        a_in = 8'h5A; pulse_ab();
        b_in = 8'hC3; pulse_ba();
        #1;
        chk("R1 idle a_oe", {7'd0, a_oe}, 8'h00);
        chk("R1 idle b_oe", {7'd0, b_oe}, 8'h00);
        a_in = 8'h11; b_in = 8'h22;

        // R1 R2 R3 R4 R5: every control combination
        for (int i = 0; i < 16; i++) begin
            @(posedge clk);
            {oe_n, dir, sel_ab, sel_ba} = VEC[i][5:2];
            @(negedge clk);
            chk("R2 a_oe", {7'd0, a_oe}, {7'd0, VEC[i][1]});
            chk("R2 b_oe", {7'd0, b_oe}, {7'd0, VEC[i][0]});
            chk("R3 single driver", {7'd0, a_oe & b_oe}, 8'h00);
            chk("R4 b_out", b_out, VEC[i][3] ? 8'h5A : 8'h11);
            chk("R5 a_out", a_out, VEC[i][2] ? 8'hC3 : 8'h22);
        end

        // R6: rising edge does not load, falling edge does
        @(posedge clk);
        oe_n = 1'b0; dir = 1'b1; sel_ab = 1'b1; a_in = 8'hFF;
        clk_ab = 1'b1; #1;
        chk("R6 rising edge ignored", b_out, 8'h5A);
        clk_ab = 1'b0; #1;
        chk("R6 falling edge load", b_out, 8'hFF);

        // R7 R8: B-to-A load while bus B is driven
        sel_ab = 1'b0; sel_ba = 1'b1; b_in = 8'h3C;
        pulse_ba();
        dir = 1'b0; #1;
        chk("R7 load while driving", a_out, 8'h3C);

        // R8: both registers in the same instant
        sel_ab = 1'b1; a_in = 8'h81; b_in = 8'h7E;
        clk_ab = 1'b1; clk_ba = 1'b1; #2;
        clk_ab = 1'b0; clk_ba = 1'b0; #1;
        chk("R8 dual load ab", b_out, 8'h81);
        chk("R8 dual load ba", a_out, 8'h7E);

        // R6: input change between edges is not stored
        a_in = 8'h00; b_in = 8'h00; #1;
        chk("R6 hold ab", b_out, 8'h81);
        chk("R7 hold ba", a_out, 8'h7E);

        // R4 R5: select change shows stored data without delay
        sel_ab = 1'b0; #1;
        chk("R4 back to live", b_out, 8'h00);
        sel_ab = 1'b1; #1;
        chk("R4 stored same cycle", b_out, 8'h81);

        // R9: asynchronous clear mid-run
        @(negedge clk);
        rst_n = 1'b0; #1;
        chk("R9 async clear ab", b_out, 8'h00);
        chk("R9 async clear ba", a_out, 8'h00);
        rst_n = 1'b1;

        @(posedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule